// File: doc/BRIEF.md
# MDIO Management Master

This block is the host-side master of a two-wire PHY management bus. A host agent hands it one register command at a time: a read or a write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block turns the command into a serial frame. The frame is a run of preamble ones, then the start pattern, the opcode, both addresses, a turnaround field and the data word. It places each bit on the data line as the management clock falls, so the PHY can sample it on the next rising edge.

The management clock is divided down from the host clock and sits high whenever no frame is in flight. The data line reaches the pad as three plain signals: data out, output enable and data in. The tri-state buffer is built outside the block. During a read the block releases the line from the turnaround field onward and collects the PHY's 16 bits into a read-data register. A read of the status register (address 1) also refreshes a link-fail flag. The flag holds the inverse of data bit 2 and keeps its value until the next status read.

Commands enter through a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the frame has finished and the management clock is high again. The host must hold `cmd_valid` and the command fields steady until the command is taken. A request made while `cmd_ready` is low is not queued. Results use plain status pins: `busy`, a one-cycle `done` pulse, `rd_data` and `link_fail`.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc` is 1, `mdo` is 1, `mdo_oe` is 0, `busy` is 0, `done` is 0, `cmd_ready` is 1, `rd_data` is 0 and `link_fail` is 0.
- R2: A command is taken only on an edge where `cmd_valid` and `cmd_ready` are both high, and `busy` is high on the following cycle. While `cmd_ready` is low, `cmd_valid` starts no frame, so every bit the PHY sees belongs to a command that was taken.
- R3: `mdc` is 1 while no frame is in flight. During a frame, each high and each low phase lasts exactly HALF_DIV host clocks. `mdo` changes only in the host cycle in which `mdc` falls.
- R4: Each frame opens with PRE_BITS bits of 1, each sampled with `mdo_oe` = 1.
- R5: For a write, the 32 frame bits after the preamble are sent MSB first with `mdo_oe` = 1 throughout, in this order: start 0,1; opcode 0,1; PHY address; register address; turnaround 1,0; data word.
- R6: For a read, the start bits 0,1, opcode 1,0 and both addresses are driven MSB first. `mdo_oe` is 0 from the first turnaround bit through the last data bit, and it is 0 whenever `busy` is 0.
- R7: For a read, `mdi` is sampled once per bit, in the last host cycle of each `mdc` high phase. The 16 data bits that follow the turnaround, MSB first, appear on `rd_data` once the frame is done. A write leaves `rd_data` unchanged.
- R8: A read of register address 1 sets `link_fail` to the inverse of received data bit 2. Reads of other registers and all writes leave `link_fail` unchanged, and it changes only during a frame.
- R9: `busy` stays high from the taking of the command until the last frame bit has been sampled. `done` is then high for exactly one cycle, the first cycle with `busy` low, and by then all PRE_BITS+32 bits have had their rising `mdc` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address inside the PHY |
| cmd_wdata | input | 16 | Data word for a write |
| rd_data | output | 16 | Data word from the last read |
| link_fail | output | 1 | Inverse of bit 2 from the last read of register 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after a frame ends |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data toward the pad |
| mdo_oe | output | 1 | Output enable for the pad driver |
| mdi | input | 1 | Serial data from the pad |

## Verification
The bench builds the block with HALF_DIV = 2 and PRE_BITS = 8. A full frame then takes about 170 host clocks, so a run can hold eight commands. The short divider still gives each `mdc` phase more than one host cycle, so the phase-length check and the rule that `mdo` holds steady while `mdc` is high are both tested. The shortened preamble leaves every field offset relative to the preamble length, so the load, capture and output-enable points are reached at shifted bit counts instead of the default ones.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 32;
  localparam logic [4:0] STATUS_REG = 5'd1;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic strobe
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          active;
  logic          wrap;

  // keep running after run drops until mdc is back high
  assign active = run | ~mdc_q;
  assign wrap   = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b1;
    end else if (!active) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mdc    = mdc_q;
  assign strobe = run & mdc_q & wrap;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       strobe,
  input  cmd_t       cmd_in,
  output cmd_t       cmd_q,
  output logic       busy,
  output logic       done,
  output logic [3:0] load_sel,
  output logic       cap_hi,
  output logic       cap_lo,
  output logic       out_pre,
  output logic       drive_en
);
  localparam int TOTAL = PRE_BITS + FRAME_BITS;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL);
  localparam logic [IW-1:0] HI_CAP   = IW'(PRE_BITS + 24);
  localparam logic [IW-1:0] OE_END   = IW'(PRE_BITS + 15);
  localparam logic [IW-1:0] PRE_END  = IW'(PRE_BITS);

  // idx = 1 + index of the bit currently on the line (0: before first fall)
  logic [IW-1:0] idx;
  logic          step;

  assign step = busy & strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cmd_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx   <= '0;
        busy  <= 1'b1;
        cmd_q <= cmd_in;
      end else if (step) begin
        if (idx == LAST_IDX) begin
          idx  <= '0;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // byte k is loaded on the fall that starts frame bit 8*k
  for (genvar k = 0; k < 4; k++) begin : g_load
    localparam logic [IW-1:0] AT = IW'(PRE_BITS + 8 * k);
    assign load_sel[k] = step & (idx == AT);
  end

  assign cap_hi   = step & ~cmd_q.wr & (idx == HI_CAP);
  assign cap_lo   = step & ~cmd_q.wr & (idx == LAST_IDX);
  assign out_pre  = (idx <= PRE_END);
  assign drive_en = busy & (cmd_q.wr | (idx < OE_END));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strobe,
  input  logic [3:0]  load_sel,
  input  cmd_t        cmd,
  input  logic        mdi,
  input  logic        cap_hi,
  input  logic        cap_lo,
  output logic        sr_msb,
  output logic [15:0] rdata,
  output logic        link_fail
);
  logic [7:0] sr;
  logic [7:0] nxt;

  assign nxt = {sr[6:0], mdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      rdata     <= '0;
      link_fail <= 1'b0;
    end else if (strobe) begin
      if (load_sel[0])      sr <= {2'b01, ~cmd.wr, cmd.wr, cmd.phy[4:1]};
      else if (load_sel[1]) sr <= {cmd.phy[0], cmd.regad, 2'b10};
      else if (load_sel[2]) sr <= cmd.wdata[15:8];
      else if (load_sel[3]) sr <= cmd.wdata[7:0];
      else                  sr <= nxt;
      if (cap_hi) rdata[15:8] <= nxt;
      if (cap_lo) begin
        rdata[7:0] <= nxt;
        // data bit 2 still sits one place short of its final slot
        if (cmd.regad == STATUS_REG) link_fail <= ~sr[1];
      end
    end
  end

  assign sr_msb = sr[7];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic [15:0] rd_data,
  output logic        link_fail,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_oe,
  input  logic        mdi
);
  cmd_t       cmd_in;
  cmd_t       cmd_q;
  logic       strobe;
  logic       start;
  logic [3:0] load_sel;
  logic       cap_hi;
  logic       cap_lo;
  logic       out_pre;
  logic       sr_msb;

  assign cmd_in    = '{wr: cmd_write, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};
  assign cmd_ready = ~busy & mdc;
  assign start     = cmd_valid & cmd_ready;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc), .strobe(strobe)
  );

  mdio_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe),
    .cmd_in(cmd_in), .cmd_q(cmd_q), .busy(busy), .done(done),
    .load_sel(load_sel), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .out_pre(out_pre), .drive_en(mdo_oe)
  );

  mdio_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .load_sel(load_sel),
    .cmd(cmd_q), .mdi(mdi), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .sr_msb(sr_msb), .rdata(rd_data), .link_fail(link_fail)
  );

  assign mdo = (~busy | out_pre) ? 1'b1 : sr_msb;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 20
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdo,
  input logic mdo_oe,
  input logic link_fail
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_mdo_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdo));

  if (HALF_DIV > 1) begin : g_phase
    p_mdc_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc != $past(mdc)) |=> (mdc == $past(mdc)));
  end

  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdo_oe);

  p_link_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_fail) |-> $past(busy));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe),
  .link_fail(link_fail)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int HD  = 2;
  localparam int PRE = 8;
  localparam int TOT = PRE + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] rd_data;
  logic        link_fail;
  logic        busy, done, mdc, mdo, mdo_oe;
  logic        mdi = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HD), .PRE_BITS(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .rd_data(rd_data), .link_fail(link_fail),
    .busy(busy), .done(done), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  int checks = 0;
  int errors = 0;
  int ops_done = 0;
  bit finished = 1'b0;

  logic [1:0]  exp_bits[$];   // {oe, value}
  logic [16:0] exp_res[$];    // {link_fail, rd_data}
  logic [15:0] m_rd = '0;
  logic        m_link = 1'b0;
  logic        cur_wr = 1'b1;
  logic [15:0] cur_resp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: predicts the frame and result, then offers the command
  task automatic do_op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] resp, input bit poke);
    logic [31:0] fr;
    fr = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0)};
    for (int i = 0; i < PRE; i++) exp_bits.push_back(2'b11);
    for (int f = 0; f < 32; f++) begin
      logic oe;
      oe = wr || (f < 14);
      exp_bits.push_back({oe, oe ? fr[31-f] : 1'b0});
    end
    if (!wr) begin
      m_rd = resp;
      if (rg == 5'd1) m_link = ~resp[2];
    end
    exp_res.push_back({m_link, m_rd});
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cur_wr = wr; cur_resp = resp;
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      // request offered while not ready must start nothing
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_phy = 5'h1A; cmd_reg = 5'h01; cmd_wdata = 16'hDEAD;
      repeat (6) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (ops_done < checks_target()) @(negedge clk);
  endtask

  int launched = 0;
  function automatic int checks_target();
    return launched;
  endfunction

  // monitor: PHY model, bit scoreboard, phase timing, result scoreboard
  logic prev_mdc = 1'b1;
  int   bitpos = 0;
  int   phase_cnt = 0;
  bit   phase_ok = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      phase_cnt++;
      if (mdc !== prev_mdc) begin
        if (busy && phase_ok)
          chk(phase_cnt == HD, "R3 mdc phase length", phase_cnt, HD);
        phase_ok  = busy;
        phase_cnt = 0;
        if (busy && mdc === 1'b0)
          chk(1'b1, "R3 fall", 0, 0);
      end else if (mdc === 1'b1 && prev_mdc === 1'b1 && busy) begin
        // mdo must hold during a high phase
      end
      if (mdc === 1'b1 && prev_mdc === 1'b0 && busy) begin
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R2 bit with no command", bitpos, 0);
        end else begin
          logic [1:0] e;
          string tag;
          int f;
          e = exp_bits.pop_front();
          f = bitpos - PRE;
          if (bitpos < PRE) tag = "R4 preamble bit";
          else if (cur_wr) tag = "R5 write frame bit";
          else tag = "R6 read frame bit";
          chk((mdo_oe === e[1]) && (!e[1] || mdo === e[0]), tag,
              {bitpos[15:0], 6'd0, mdo_oe, mdo}, {bitpos[15:0], 6'd0, e});
          // PHY drives its bit after the rising edge
          if (!cur_wr && f >= 16) mdi = cur_resp[31-f];
          else if (!cur_wr && f == 15) mdi = 1'b0;
          else mdi = 1'b1;
        end
        bitpos++;
      end
      if (done) begin
        logic [16:0] r;
        chk(exp_bits.size() == 0, "R9 all bits sent before done", exp_bits.size(), 0);
        chk(bitpos == TOT, "R9 bit count", bitpos, TOT);
        chk(busy === 1'b0, "R9 busy low at done", {31'd0, busy}, 0);
        if (exp_res.size() != 0) begin
          r = exp_res.pop_front();
          chk(rd_data === r[15:0], "R7 read data", rd_data, r[15:0]);
          chk(link_fail === r[16], "R8 link fail", {31'd0, link_fail}, {31'd0, r[16]});
        end
        bitpos = 0;
        mdi = 1'b1;
        ops_done++;
      end
      if (done && $past(done)) chk(1'b0, "R9 done wider than one cycle", 1, 0);
      prev_mdc = mdc;
    end
  end

  // separate watch on mdo staying put while mdc is high
  logic prev_mdo = 1'b1;
  logic prev_mdc2 = 1'b1;
  always @(negedge clk) begin
    if (rst_n && busy && mdc && prev_mdc2 && (mdo !== prev_mdo))
      chk(1'b0, "R3 mdo moved while mdc high", {31'd0, mdo}, {31'd0, prev_mdo});
    prev_mdo  = mdo;
    prev_mdc2 = mdc;
  end

  task automatic op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                    input logic [15:0] wd, input logic [15:0] resp, input bit poke);
    launched++;
    do_op(wr, phy, rg, wd, resp, poke);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc === 1'b1,        "R1 mdc reset", {31'd0, mdc}, 1);
    chk(mdo === 1'b1,        "R1 mdo reset", {31'd0, mdo}, 1);
    chk(mdo_oe === 1'b0,     "R1 oe reset", {31'd0, mdo_oe}, 0);
    chk(busy === 1'b0,       "R1 busy reset", {31'd0, busy}, 0);
    chk(done === 1'b0,       "R1 done reset", {31'd0, done}, 0);
    chk(cmd_ready === 1'b1,  "R1 ready reset", {31'd0, cmd_ready}, 1);
    chk(rd_data === 16'h0,   "R1 rd_data reset", rd_data, 0);
    chk(link_fail === 1'b0,  "R1 link reset", {31'd0, link_fail}, 0);

    op(1'b1, 5'h11, 5'h04, 16'hA5C3, 16'h0000, 1'b0); // R5 write
    op(1'b0, 5'h03, 5'h02, 16'h0000, 16'h1234, 1'b1); // R6 R7 read, R2 poke
    op(1'b0, 5'h03, 5'h01, 16'h0000, 16'h7869, 1'b0); // R8 bit2=0 -> 1
    op(1'b1, 5'h03, 5'h01, 16'h0004, 16'h0000, 1'b0); // R8 R7 write keeps state
    op(1'b0, 5'h03, 5'h03, 16'h0000, 16'h0000, 1'b0); // R8 other reg keeps flag
    op(1'b0, 5'h1F, 5'h01, 16'h0000, 16'hFFFF, 1'b0); // R8 bit2=1 -> 0
    op(1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h8001, 1'b0); // R7 edge bits
    op(1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0000, 1'b0); // R5 all-ones data

    repeat (40) @(negedge clk);
    chk(mdc === 1'b1,    "R3 mdc idles high", {31'd0, mdc}, 1);
    chk(busy === 1'b0,   "R2 no extra frame", {31'd0, busy}, 0);
    chk(ops_done == 8,   "R9 done count", ops_done, 8);
    chk(mdo_oe === 1'b0, "R6 oe low when idle", {31'd0, mdo_oe}, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule